// File: doc/BRIEF.md
# Four-Slot Statically Scheduled Bundle Core

This block is a small in-order processor core. Each cycle it fetches one 128-bit bundle and executes its four fixed 32-bit slots together: two integer arithmetic slots, one load/store slot and one branch slot. The compiler packs every bundle. The core has no hazard detection, interlocking, renaming or forwarding. It reads every source operand from the register state as it stood when the cycle began, and it commits all results together at the clock edge that ends the cycle.

Instruction memory and data memory sit outside the core. Both are read combinationally. The fetch port presents the program counter as a byte address and expects the bundle on the same cycle. The single data port carries at most one word access per bundle, and a load returns its value within the cycle. Decode, execute, writeback and the program-counter update are all inside the core.

Top module: `bundle_core`

## Requirements
- R1: A bundle is 128 bits and holds four 32-bit slots. Bits 127:96 are slot 0 (arithmetic A), bits 95:64 are slot 1 (arithmetic B), bits 63:32 are slot 2 (memory) and bits 31:0 are slot 3 (branch). One bundle issues per cycle, and without a taken branch the fetch address advances by 16.
- R2: A slot is laid out as opcode[31:26], rd[25:21], rs1[20:16], rs2[15:11] and imm[10:0], where imm is sign-extended. An all-zero slot is a NOP and has no architectural effect. Any opcode a slot does not recognise also has no effect.
- R3: The arithmetic slots execute function codes 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 shift left, 7 logical shift right and 8 multiply-low (the low 32 bits of the product). These codes go in opcode bits 3:0 with opcode bit 4 clear. Opcode bit 5 selects the immediate in place of rs2 as the second operand. Shifts use the low 5 bits of that operand. The result is written to rd.
- R4: Only the memory slot reaches data memory. Opcode 0x10 loads the word at byte address rs1+imm into rd. Opcode 0x11 stores rs2 to rs1+imm. The same opcodes in any other slot do nothing, and a memory slot holding neither opcode leaves both the read and write strobes low.
- R5: Every source operand reads the register value from the start of the cycle, even when another slot in the same bundle writes that register.
- R6: Register 0 always reads zero, and any write to it is dropped.
- R7: When several slots of one bundle write the same register, the slot with the higher index wins. Load beats arithmetic B, and arithmetic B beats arithmetic A.
- R8: The branch slot compares rs1 with rs2. Opcode 0x18 branches on equal, 0x19 on not equal and 0x1A on signed less-than. When taken, the next fetch address is the current one plus the sign-extended immediate times 16. Otherwise it is the current one plus 16.
- R9: A synchronous active-high reset sets the fetch address to 0 and clears every register.
- R10: A result written by a bundle, including a loaded word, is visible to the very next bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the bundle to fetch |
| imem_word | input | 128 | Bundle at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_re | output | 1 | Load strobe for this cycle |
| dmem_we | output | 1 | Store strobe for this cycle |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Word read at dmem_addr, same cycle |

## Verification
A hand-scheduled bundle sequence covers several cases with known final values: a same-bundle register swap, a three-way write conflict, a write to register 0, a load opcode placed in an arithmetic slot, a counted loop that accumulates loaded words, and a forward signed branch. These cases separate start-of-cycle operand reads from forwarded ones, and show which slot wins a conflict. Seeded random bundles then mix every arithmetic code in both operand forms, with loads, stores and short forward branches over eight registers, so conflicts and same-bundle reuse occur often. These runs are compared cycle by cycle against a bench model of the fetch address and the memory strobes. A register dump through stores compares the final state. A separate run after a reset dumps all registers to show that they were cleared.

// File: rtl/bundle_pkg.sv
package bundle_pkg;
  localparam int XLEN       = 32;
  localparam int SLOTS      = 4;
  localparam int SLOT_W     = 32;
  localparam int IMM_W      = 11;
  localparam int WORD_W     = SLOTS * SLOT_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int PC_SHIFT   = $clog2(WORD_BYTES);
  localparam int SHAMT_W    = $clog2(XLEN);

  localparam logic [5:0] OP_LOAD  = 6'h10;
  localparam logic [5:0] OP_STORE = 6'h11;
  localparam logic [5:0] OP_BEQ   = 6'h18;
  localparam logic [5:0] OP_BNE   = 6'h19;
  localparam logic [5:0] OP_BLT   = 6'h1A;

  typedef struct packed {
    logic [5:0]       op;
    logic [4:0]       rd;
    logic [4:0]       rs1;
    logic [4:0]       rs2;
    logic [IMM_W-1:0] imm;
  } slot_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic alu_op_valid(input logic [5:0] op);
    return (op[4] == 1'b0) && (op[3:0] >= 4'd1) && (op[3:0] <= 4'd8);
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input logic [3:0] fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (fn)
      4'd1: r = a + b;
      4'd2: r = a - b;
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd6: r = a << b[SHAMT_W-1:0];
      4'd7: r = a >> b[SHAMT_W-1:0];
      4'd8: r = a * b;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic branch_eval(input logic [5:0] op,
                                       input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
    logic t;
    case (op)
      OP_BEQ:  t = (a == b);
      OP_BNE:  t = (a != b);
      OP_BLT:  t = ($signed(a) < $signed(b));
      default: t = 1'b0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/bundle_regfile.sv
module bundle_regfile
  import bundle_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NRD   = 8,
  parameter int NWR   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NRD-1:0][$clog2(NREGS)-1:0] rd_addr,
  output logic [NRD-1:0][XLEN-1:0]      rd_data,
  input  logic [NWR-1:0]                wr_en,
  input  logic [NWR-1:0][$clog2(NREGS)-1:0] wr_addr,
  input  logic [NWR-1:0][XLEN-1:0]      wr_data
);
  logic [XLEN-1:0] regs [NREGS];

  // later write ports overwrite earlier ones: higher slot index wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREGS; r++) regs[r] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++) begin
        if (wr_en[p] && (wr_addr[p] != '0)) regs[wr_addr[p]] <= wr_data[p];
      end
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = (rd_addr[g] == '0) ? '0 : regs[rd_addr[g]];
  end
endmodule

// File: rtl/bundle_alu_slot.sv
module bundle_alu_slot
  import bundle_pkg::*;
(
  input  slot_t           ins,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            wr_en,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] operand_b;
  logic            unused_fields;

  assign operand_b     = ins.op[5] ? sext_imm(ins.imm) : opb;
  assign wr_en         = alu_op_valid(ins.op);
  assign result        = alu_calc(ins.op[3:0], opa, operand_b);
  assign unused_fields = ^{ins.rd, ins.rs1, ins.rs2};
endmodule

// File: rtl/bundle_branch_unit.sv
module bundle_branch_unit
  import bundle_pkg::*;
(
  input  slot_t           ins,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] pc,
  output logic            taken,
  output logic [XLEN-1:0] pc_next
);
  logic [XLEN-1:0] offset;
  logic            unused_fields;

  assign taken         = branch_eval(ins.op, opa, opb);
  assign offset        = sext_imm(ins.imm) << PC_SHIFT;
  assign pc_next       = taken ? (pc + offset) : (pc + XLEN'(WORD_BYTES));
  assign unused_fields = ^{ins.rd, ins.rs1, ins.rs2};
endmodule

// File: rtl/bundle_core.sv
module bundle_core
  import bundle_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [31:0]   imem_addr,
  input  logic [127:0]  imem_word,
  output logic [31:0]   dmem_addr,
  output logic          dmem_re,
  output logic          dmem_we,
  output logic [31:0]   dmem_wdata,
  input  logic [31:0]   dmem_rdata
);
  localparam int AW       = $clog2(NREGS);
  localparam int NRD      = 2 * SLOTS;
  localparam int N_ALU    = 2;
  localparam int MEM_SLOT = 2;
  localparam int BR_SLOT  = 3;
  localparam int NWR      = N_ALU + 1;

  slot_t slot [SLOTS];
  for (genvar g = 0; g < SLOTS; g++) begin : g_split
    assign slot[g] = slot_t'(imem_word[SLOT_W*(SLOTS-g)-1 -: SLOT_W]);
  end

  logic [NRD-1:0][AW-1:0]   rd_addr;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  for (genvar g = 0; g < SLOTS; g++) begin : g_src
    assign rd_addr[2*g]   = slot[g].rs1[AW-1:0];
    assign rd_addr[2*g+1] = slot[g].rs2[AW-1:0];
  end

  logic [NWR-1:0]           wr_en;
  logic [NWR-1:0][AW-1:0]   wr_addr;
  logic [NWR-1:0][XLEN-1:0] wr_data;

  // named events for the checker
  logic [N_ALU-1:0] alu_wr_en;
  logic             load_wr;
  logic             store_req;
  logic             br_taken;
  logic [XLEN-1:0]  pc_next;
  logic [XLEN-1:0]  pc;

  for (genvar g = 0; g < N_ALU; g++) begin : g_alu
    bundle_alu_slot u_alu (
      .ins    (slot[g]),
      .opa    (rd_data[2*g]),
      .opb    (rd_data[2*g+1]),
      .wr_en  (alu_wr_en[g]),
      .result (wr_data[g])
    );
    assign wr_en[g]   = alu_wr_en[g];
    assign wr_addr[g] = slot[g].rd[AW-1:0];
  end

  assign load_wr       = (slot[MEM_SLOT].op == OP_LOAD);
  assign store_req     = (slot[MEM_SLOT].op == OP_STORE);
  assign dmem_re       = load_wr;
  assign dmem_we       = store_req;
  assign dmem_addr     = rd_data[2*MEM_SLOT] + sext_imm(slot[MEM_SLOT].imm);
  assign dmem_wdata    = rd_data[2*MEM_SLOT+1];
  assign wr_en[N_ALU]   = load_wr;
  assign wr_addr[N_ALU] = slot[MEM_SLOT].rd[AW-1:0];
  assign wr_data[N_ALU] = dmem_rdata;

  bundle_regfile #(.NREGS(NREGS), .NRD(NRD), .NWR(NWR)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  bundle_branch_unit u_br (
    .ins     (slot[BR_SLOT]),
    .opa     (rd_data[2*BR_SLOT]),
    .opb     (rd_data[2*BR_SLOT+1]),
    .pc      (pc),
    .taken   (br_taken),
    .pc_next (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr = pc;
endmodule

// File: rtl/bundle_core_chk.sv
module bundle_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [5:0]  mem_op,
  input logic [10:0] br_imm,
  input logic        dmem_re,
  input logic        dmem_we,
  input logic        br_taken
);
  logic [31:0] taken_target;
  assign taken_target = imem_addr + {{17{br_imm[10]}}, br_imm, 4'b0000};

  a_r1_sequential_fetch: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> imem_addr == $past(imem_addr) + 32'd16);

  a_r8_taken_target: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> imem_addr == $past(taken_target));

  a_r1_fetch_aligned: assert property (@(posedge clk) disable iff (rst)
    imem_addr[3:0] == 4'b0000);

  a_r4_load_strobe: assert property (@(posedge clk) disable iff (rst)
    (mem_op == 6'h10) |-> (dmem_re && !dmem_we));

  a_r4_store_strobe: assert property (@(posedge clk) disable iff (rst)
    (mem_op == 6'h11) |-> (dmem_we && !dmem_re));

  a_r4_idle_port: assert property (@(posedge clk) disable iff (rst)
    (mem_op != 6'h10 && mem_op != 6'h11) |-> (!dmem_re && !dmem_we));
endmodule

bind bundle_core bundle_core_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .mem_op    (imem_word[63:58]),
  .br_imm    (imem_word[10:0]),
  .dmem_re   (dmem_re),
  .dmem_we   (dmem_we),
  .br_taken  (br_taken)
);

// File: tb/test_bundle_core.sv
`timescale 1ns/1ps
module test_bundle_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  imem_addr;
  logic [127:0] imem_word;
  logic [31:0]  dmem_addr;
  logic         dmem_re;
  logic         dmem_we;
  logic [31:0]  dmem_wdata;
  logic [31:0]  dmem_rdata;

  logic [127:0] imem [64];
  logic [31:0]  dmem [64];
  logic [31:0]  mreg [32];
  logic [31:0]  mdmem [64];
  logic [31:0]  mpc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign imem_word  = imem[imem_addr[9:4]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  bundle_core i_bundle_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_word(imem_word),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input int rd, input int rs1,
                                     input int rs2, input int imm);
    return {op, 5'(rd), 5'(rs1), 5'(rs2), 11'(imm)};
  endfunction

  function automatic logic [31:0] ext(input logic [10:0] v);
    return {{21{v[10]}}, v};
  endfunction

  // bench arithmetic model: returns validity through ok
  function automatic logic [31:0] m_alu(input logic [31:0] s, input logic [31:0] a,
                                        input logic [31:0] rb, output bit ok);
    logic [31:0] b;
    logic [5:0]  op;
    op = s[31:26];
    b  = op[5] ? ext(s[10:0]) : rb;
    ok = 1;
    case (op & 6'h1F)
      6'd1: return a + b;
      6'd2: return a - b;
      6'd3: return a & b;
      6'd4: return a | b;
      6'd5: return a ^ b;
      6'd6: return a << b[4:0];
      6'd7: return a >> b[4:0];
      6'd8: return 32'(a * b);
      default: begin ok = 0; return 32'd0; end
    endcase
  endfunction

  // compare ports against model for this bundle, then advance the model
  task automatic do_cycle();
    logic [127:0] w;
    logic [31:0]  s [4];
    logic [31:0]  nreg [32];
    logic [31:0]  res, addr, ld;
    logic         exp_re, exp_we, tk;
    bit           ok;
    w = imem[mpc[9:4]];
    for (int k = 0; k < 4; k++) s[k] = w[127-32*k -: 32];
    nreg = mreg;
    chk("R1/R8 fetch address", imem_addr, mpc);
    addr   = mreg[s[2][20:16]] + ext(s[2][10:0]);
    exp_re = (s[2][31:26] == 6'h10);
    exp_we = (s[2][31:26] == 6'h11);
    chk("R4 load strobe", {31'b0, dmem_re}, {31'b0, exp_re});
    chk("R4 store strobe", {31'b0, dmem_we}, {31'b0, exp_we});
    if (exp_re || exp_we) chk("R4 data address", dmem_addr, addr);
    if (exp_we) chk("R4 store data", dmem_wdata, mreg[s[2][15:11]]);
    if (dmem_we) dmem[dmem_addr[7:2]] = dmem_wdata;
    for (int k = 0; k < 2; k++) begin
      res = m_alu(s[k], mreg[s[k][20:16]], mreg[s[k][15:11]], ok);
      if (ok) nreg[s[k][25:21]] = res;
    end
    if (exp_re) begin
      ld = mdmem[addr[7:2]];
      nreg[s[2][25:21]] = ld;
    end
    if (exp_we) mdmem[addr[7:2]] = mreg[s[2][15:11]];
    case (s[3][31:26])
      6'h18: tk = (mreg[s[3][20:16]] == mreg[s[3][15:11]]);
      6'h19: tk = (mreg[s[3][20:16]] != mreg[s[3][15:11]]);
      6'h1A: tk = ($signed(mreg[s[3][20:16]]) < $signed(mreg[s[3][15:11]]));
      default: tk = 0;
    endcase
    mpc = tk ? mpc + (ext(s[3][10:0]) << 4) : mpc + 32'd16;
    nreg[0] = 32'd0;
    mreg = nreg;
  endtask

  task automatic run_prog(input string tag, input int ncyc);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 fetch address after reset", imem_addr, 32'd0);
    for (int r = 0; r < 32; r++) mreg[r] = 32'd0;
    for (int i = 0; i < 64; i++) mdmem[i] = dmem[i];
    mpc = 32'd0;
    for (int c = 0; c < ncyc; c++) begin
      do_cycle();
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) chk({tag, " final memory"}, dmem[i], mdmem[i]);
  endtask

  // store r1..r31 into words 32..62, starting at bundle index base
  task automatic put_dump(input int base);
    for (int k = 1; k < 32; k++)
      imem[base+k-1] = {32'd0, 32'd0, mk(6'h11, 0, 0, k, 128 + 4*(k-1)), 32'd0};
  endtask

  function automatic logic [31:0] rnd_alu();
    int r;
    logic [5:0] op;
    r = $urandom_range(0, 19);
    if (r < 2) return 32'd0;
    if (r == 2) return mk(6'h10, $urandom_range(0,7), 0, 0, 0);
    op = 6'($urandom_range(1, 8)) | ($urandom_range(0,1) ? 6'h20 : 6'h00);
    return mk(op, $urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,7),
              $urandom_range(0,2047));
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end

    // directed hand-scheduled program
    imem[0]  = {mk(6'h21,3,0,0,11), mk(6'h21,4,0,0,22), 32'd0, 32'd0};
    imem[1]  = {mk(6'h01,3,4,0,0),  mk(6'h01,4,3,0,0),  32'd0, 32'd0};           // R5 swap
    imem[2]  = {mk(6'h21,5,0,0,1),  mk(6'h21,5,0,0,2),  mk(6'h10,5,0,0,0), 32'd0}; // R7
    imem[3]  = {mk(6'h21,6,0,0,1),  mk(6'h21,6,0,0,2),  32'd0, 32'd0};
    imem[4]  = {mk(6'h21,0,0,0,7),  mk(6'h21,7,0,0,9),  32'd0, 32'd0};           // R6
    imem[5]  = {mk(6'h01,7,0,0,0),  32'd0, mk(6'h11,0,0,0,68), 32'd0};
    imem[6]  = {mk(6'h10,8,0,0,0),  32'd0, 32'd0, 32'd0};                        // R4
    imem[7]  = {mk(6'h21,2,0,0,3),  mk(6'h21,1,0,0,0),  32'd0, 32'd0};
    imem[8]  = {mk(6'h21,1,1,0,1),  mk(6'h21,11,11,0,4), mk(6'h10,10,11,0,0), 32'd0};
    imem[9]  = {mk(6'h01,9,9,10,0), 32'd0, 32'd0, mk(6'h19,0,1,2,-1)};          // R8, R10
    imem[10] = {mk(6'h28,12,9,0,3), mk(6'h26,13,2,0,4), mk(6'h11,0,0,9,64), 32'd0}; // R3
    imem[11] = {32'd0, 32'd0, 32'd0, mk(6'h1A,0,0,2,2)};
    imem[12] = {mk(6'h21,14,0,0,99), 32'd0, 32'd0, 32'd0};
    put_dump(13);
    imem[44] = {32'd0, 32'd0, 32'd0, mk(6'h18,0,0,0,0)};
    dmem[0] = 32'h55; dmem[1] = 32'h100; dmem[2] = 32'h2000; dmem[17] = 32'hFFFF;
    run_prog("R5/R7 directed", 90);
    chk("R8 loop counter r1", dmem[32], 32'd3);
    chk("R5 swap r3", dmem[34], 32'd22);
    chk("R5 swap r4", dmem[35], 32'd11);
    chk("R7 load wins r5", dmem[36], 32'h55);
    chk("R7 slot B wins r6", dmem[37], 32'd2);
    chk("R6 r0 reads zero r7", dmem[38], 32'd0);
    chk("R6 stored r0", dmem[17], 32'd0);
    chk("R4 load in arithmetic slot r8", dmem[39], 32'd0);
    chk("R10 accumulated loads r9", dmem[40], 32'h2155);
    chk("R3 multiply-low r12", dmem[43], 32'h63FF);
    chk("R3 shift immediate r13", dmem[44], 32'd48);
    chk("R8 skipped bundle r14", dmem[45], 32'd0);
    chk("R4 stored word", dmem[16], 32'h2155);

    // reset clears registers; zero bundles are NOPs
    for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = 32'hFFFFFFFF; end
    put_dump(0);
    imem[34] = {32'd0, 32'd0, 32'd0, mk(6'h18,0,0,0,0)};
    run_prog("R2/R9 reset dump", 50);
    for (int k = 1; k < 32; k++) chk("R9 register cleared", dmem[31+k], 32'd0);

    // seeded random bundles
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 64; i++) begin
        imem[i] = '0;
        dmem[i] = (i < 32) ? $urandom() : 32'd0;
      end
      for (int i = 0; i < 20; i++) begin
        logic [31:0] ms, bs;
        int m;
        m = $urandom_range(0, 2);
        ms = (m == 0) ? 32'd0 :
             mk((m == 1) ? 6'h10 : 6'h11, $urandom_range(0,7), 0, $urandom_range(0,7),
                4 * $urandom_range(0,31));
        bs = 32'd0;
        if (i < 18 && $urandom_range(0,2) == 0)
          bs = mk(6'h18 + 6'($urandom_range(0,2)), 0, $urandom_range(0,7),
                  $urandom_range(0,7), $urandom_range(1,2));
        imem[i] = {rnd_alu(), rnd_alu(), ms, bs};
      end
      put_dump(20);
      imem[51] = {32'd0, 32'd0, 32'd0, mk(6'h18,0,0,0,0)};
      run_prog("R3/R7 random", 90);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule